// File: doc/BRIEF.md
# System Clock Control with Suspend and Wake

This block turns a free-running high-frequency source clock into the system clock of a small controller. Software sees a single 8-bit control register through a plain write strobe and a combinational read bus. The register turns the source on or off, sets a power-of-two division ratio, and can force a suspend state. The suspend state stops the system clock until the bus shows activity again.

Hardware ends the suspend state by itself. There are two triggers: a resume event on the attached serial bus, or the bus-power level reaching the polarity chosen on a separate select input. After reset, enable or wake, the block waits a fixed number of source cycles for the source to settle. It then raises a ready flag and only after that lets clock pulses out.

The system clock is made by gating the source clock with an enable. That enable is retimed on the falling edge of the source, so every pulse it passes is a full source high phase. The division ratio is the number of source cycles between pulses. All control inputs are taken to be synchronous to the source clock.

Top module: `sysclk_ctrl`

## Requirements
- R1: Reset sets the register so that it reads 0x80: source enabled, not suspended, divide-by-8 code. The ready flag is low during reset.
- R2: The register fields are: bit 7 enable, bit 6 ready (read-only), bit 5 suspend, bits 1:0 ratio select. These bits read back what was written. Bits 4:2 always read 0. Writes to bits 6 and 4:2 have no effect.
- R3: Ratio select code 00 gives one system-clock pulse every 8 source cycles, 01 every 4, 10 every 2 and 11 every cycle. Each pulse covers the high phase of a source cycle.
- R4: The ready flag (output `ready` and register bit 6) rises on the 16th source rising edge after the edge where the block starts running (enable 1 and suspend 0). This includes release of reset.
- R5: The ready flag drops at the edge that clears enable or sets suspend. System-clock pulses stop from the following source cycle onward and stay low.
- R6: Writing 1 to the suspend bit stops the system clock. The suspend bit reads 1 until a wake event or a write clears it.
- R7: While enabled and suspended, a high `bus_resume` at a source rising edge clears the suspend bit at that edge, and settling restarts.
- R8: While enabled and suspended, `vbus_lvl` equal to `vbus_pol` at a rising edge clears the suspend bit at that edge. This holds for both polarity settings.
- R9: While enable is 0, wake events change nothing: the suspend bit keeps its value, ready stays low and no pulses are produced.
- R10: While not suspended, wake events change neither the register contents nor the ready flag.
- R11: A new ratio is taken up only at the end of a divided period. Every interval between pulses equals either the old or the new ratio, and once the new ratio is in use the old one does not return.
- R12: A register write and a wake event at the same edge: the write wins, so writing suspend = 1 leaves the block suspended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 1 | Free-running high-frequency source clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe, sampled at the rising edge |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read data: enable, ready, suspend, zeros, ratio select |
| bus_resume | input | 1 | Non-idle bus activity indication (wake source) |
| vbus_lvl | input | 1 | Bus-power level (wake source) |
| vbus_pol | input | 1 | Bus-power level that counts as a wake |
| sys_clk | output | 1 | Gated and divided system clock |
| ready | output | 1 | Source settled and system clock running |

## Verification
Register fields and the suspend bit change at the rising edge that takes the write or the wake, so the bench reads them at the next falling edge. The ready flag is due exactly 16 rising edges after the edge that starts the block. The bench counts falling edges from that point until it sees the flag and compares the count with 16. A system-clock pulse shows up one source cycle after the cycle that scheduled it. For that reason the bench never checks single pulse positions. It records pulses a quarter period after each rising edge and checks pulse counts over windows that are a whole number of periods long, plus the spacing between pulses. Before any pulse window it waits out the edges where a change is still taking effect.

// File: rtl/sysclk_ctrl_pkg.sv
package sysclk_ctrl_pkg;
   localparam int REG_W     = 8;
   localparam int BIT_EN    = 7;
   localparam int BIT_RDY   = 6;
   localparam int BIT_SUSP  = 5;
   localparam int FIELD_SEL = 2; // bits available for the ratio select field

   // clock-gating state seen by the divider
   typedef enum logic [1:0] {
      GS_OFF    = 2'd0,
      GS_SETTLE = 2'd1,
      GS_RUN    = 2'd2
   } gate_state_e;
endpackage

// File: rtl/sysclk_ctrl_regs.sv
module sysclk_ctrl_regs
   import sysclk_ctrl_pkg::*;
#(
   parameter int SEL_W   = 2,
   parameter int RST_SEL = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wr_data,
   input  logic             bus_resume,
   input  logic             vbus_lvl,
   input  logic             vbus_pol,
   output logic             en_o,
   output logic             susp_o,
   output logic [SEL_W-1:0] sel_o
);
   localparam logic [SEL_W-1:0] SEL_INIT = SEL_W'(RST_SEL);

   logic             en_q;
   logic             susp_q;
   logic [SEL_W-1:0] sel_q;
   logic             wake;

   // wake is honoured only when enabled and suspended
   always_comb begin
      wake = en_q & susp_q & (bus_resume | (vbus_lvl ~^ vbus_pol));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= 1'b1;
         susp_q <= 1'b0;
         sel_q  <= SEL_INIT;
      end else if (wr_en) begin
         en_q   <= wr_data[BIT_EN];
         susp_q <= wr_data[BIT_SUSP];
         sel_q  <= wr_data[SEL_W-1:0];
      end else if (wake) begin
         susp_q <= 1'b0;
      end
   end

   assign en_o   = en_q;
   assign susp_o = susp_q;
   assign sel_o  = sel_q;
endmodule

// File: rtl/sysclk_ctrl_settle.sv
module sysclk_ctrl_settle #(
   parameter int SETTLE_CYC = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   output logic ready_o
);
   generate
      if (SETTLE_CYC == 0) begin : g_no_wait
         assign ready_o = run_i;
      end else begin : g_wait
         localparam int CNT_W = $clog2(SETTLE_CYC + 1);
         localparam logic [CNT_W-1:0] LAST = CNT_W'(SETTLE_CYC - 1);

         logic [CNT_W-1:0] cnt_q;
         logic             rdy_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
               rdy_q <= 1'b0;
            end else if (!run_i) begin
               cnt_q <= '0;
               rdy_q <= 1'b0;
            end else if (!rdy_q) begin
               if (cnt_q == LAST) begin
                  rdy_q <= 1'b1;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
         end

         // drop at once when the run condition goes away
         assign ready_o = rdy_q & run_i;
      end
   endgenerate
endmodule

// File: rtl/sysclk_ctrl_divgate.sv
module sysclk_ctrl_divgate
   import sysclk_ctrl_pkg::*;
#(
   parameter int SEL_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_i,
   input  logic             active_i,
   input  logic [SEL_W-1:0] sel_i,
   output logic             sys_clk_o
);
   localparam int MAXSH = (1 << SEL_W) - 1; // log2 of the largest ratio
   localparam int PH_W  = (MAXSH < 1) ? 1 : MAXSH;

   logic [PH_W-1:0]  ph_q;
   logic [SEL_W-1:0] cur_q;
   logic [PH_W-1:0]  last_ph;
   logic             tick;
   logic             gate_q;
   gate_state_e      gs;

   always_comb begin
      if (!run_i)         gs = GS_OFF;
      else if (!active_i) gs = GS_SETTLE;
      else                gs = GS_RUN;
   end

   // code 0 is the largest ratio, all-ones is divide by one
   always_comb begin
      last_ph = PH_W'((32'd1 << (MAXSH - int'(cur_q))) - 32'd1);
      tick    = (gs == GS_RUN) && (ph_q == '0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q  <= '0;
         cur_q <= '0;
      end else if (gs != GS_RUN) begin
         ph_q  <= '0;
         cur_q <= sel_i;
      end else if (ph_q == last_ph) begin
         ph_q  <= '0;
         cur_q <= sel_i; // new ratio only at a period boundary
      end else begin
         ph_q  <= ph_q + 1'b1;
      end
   end

   // enable retimed while the source is high, used on the next high phase
   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) gate_q <= 1'b0;
      else        gate_q <= tick;
   end

   assign sys_clk_o = clk & gate_q;
endmodule

// File: rtl/sysclk_ctrl.sv
module sysclk_ctrl
   import sysclk_ctrl_pkg::*;
#(
   parameter int SETTLE_CYC = 16,
   parameter int SEL_W      = 2,
   parameter int RST_SEL    = 0
) (
   input  logic             src_clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wr_data,
   output logic [REG_W-1:0] rd_data,
   input  logic             bus_resume,
   input  logic             vbus_lvl,
   input  logic             vbus_pol,
   output logic             sys_clk,
   output logic             ready
);
   generate
      if (SEL_W < 1 || SEL_W > FIELD_SEL) begin : g_bad_sel
         $error("sysclk_ctrl: SEL_W must be 1..%0d", FIELD_SEL);
      end
      if (RST_SEL < 0 || RST_SEL >= (1 << SEL_W)) begin : g_bad_rst
         $error("sysclk_ctrl: RST_SEL out of range");
      end
      if (SETTLE_CYC < 0) begin : g_bad_settle
         $error("sysclk_ctrl: SETTLE_CYC must not be negative");
      end
   endgenerate

   logic             en;
   logic             susp;
   logic [SEL_W-1:0] sel;
   logic             run;
   logic             rdy;

   sysclk_ctrl_regs #(.SEL_W(SEL_W), .RST_SEL(RST_SEL)) u_regs (
      .clk        (src_clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .wr_data    (wr_data),
      .bus_resume (bus_resume),
      .vbus_lvl   (vbus_lvl),
      .vbus_pol   (vbus_pol),
      .en_o       (en),
      .susp_o     (susp),
      .sel_o      (sel)
   );

   assign run = en & ~susp;

   sysclk_ctrl_settle #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
      .clk     (src_clk),
      .rst_n   (rst_n),
      .run_i   (run),
      .ready_o (rdy)
   );

   sysclk_ctrl_divgate #(.SEL_W(SEL_W)) u_div (
      .clk       (src_clk),
      .rst_n     (rst_n),
      .run_i     (run),
      .active_i  (rdy),
      .sel_i     (sel),
      .sys_clk_o (sys_clk)
   );

   always_comb begin
      rd_data           = '0;
      rd_data[BIT_EN]   = en;
      rd_data[BIT_RDY]  = rdy;
      rd_data[BIT_SUSP] = susp;
      rd_data[SEL_W-1:0] = sel;
   end

   assign ready = rdy;
endmodule

// File: rtl/sysclk_ctrl_chk.sv
module sysclk_ctrl_chk #(
   parameter int SETTLE_CYC = 16
) (
   input logic       src_clk,
   input logic       rst_n,
   input logic       wr_en,
   input logic [7:0] wr_data,
   input logic [7:0] rd_data,
   input logic       bus_resume,
   input logic       vbus_lvl,
   input logic       vbus_pol,
   input logic       ready
);
   int  run_cnt;
   logic running;

   assign running = rd_data[7] & ~rd_data[5];

   always_ff @(posedge src_clk or negedge rst_n) begin
      if (!rst_n)                    run_cnt <= 0;
      else if (!running)             run_cnt <= 0;
      else if (run_cnt < SETTLE_CYC) run_cnt <= run_cnt + 1;
   end

   // R4: ready only after the full settling window of running edges
   a_r4_settled: assert property (@(posedge src_clk) disable iff (!rst_n)
      ready |-> (run_cnt >= SETTLE_CYC));

   // R7: resume activity ends suspend
   a_r7_resume_wakes: assert property (@(posedge src_clk) disable iff (!rst_n)
      (rd_data[7] && rd_data[5] && bus_resume && !wr_en) |=> !rd_data[5]);

   // R8: matching bus-power level ends suspend
   a_r8_vbus_wakes: assert property (@(posedge src_clk) disable iff (!rst_n)
      (rd_data[7] && rd_data[5] && (vbus_lvl == vbus_pol) && !wr_en) |=> !rd_data[5]);

   // R9: disabled block keeps its state regardless of wake events
   a_r9_disabled_holds: assert property (@(posedge src_clk) disable iff (!rst_n)
      (!rd_data[7] && !wr_en) |=> (!rd_data[7] && !ready && (rd_data[5] == $past(rd_data[5]))));

   // R2: written fields read back on the next cycle
   a_r2_write_back: assert property (@(posedge src_clk) disable iff (!rst_n)
      wr_en |=> ((rd_data[7] == $past(wr_data[7])) && (rd_data[1:0] == $past(wr_data[1:0]))
                 && (rd_data[4:2] == 3'b000)));

   // R12: a write beats a simultaneous wake
   a_r12_write_first: assert property (@(posedge src_clk) disable iff (!rst_n)
      (wr_en && wr_data[5] && wr_data[7]) |=> rd_data[5]);
endmodule

bind sysclk_ctrl sysclk_ctrl_chk #(.SETTLE_CYC(SETTLE_CYC)) u_chk (
   .src_clk    (src_clk),
   .rst_n      (rst_n),
   .wr_en      (wr_en),
   .wr_data    (wr_data),
   .rd_data    (rd_data),
   .bus_resume (bus_resume),
   .vbus_lvl   (vbus_lvl),
   .vbus_pol   (vbus_pol),
   .ready      (ready)
);

// File: tb/sysclk_ctrl_test.sv
module sysclk_ctrl_test;
   localparam int CLK_P  = 10;
   localparam int SETTLE = 16;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic [7:0] rd_data;
   logic       bus_resume = 1'b0;
   logic       vbus_lvl = 1'b0;
   logic       vbus_pol = 1'b1;
   logic       sys_clk;
   logic       ready;

   int n_chk = 0;
   int n_err = 0;
   int cyc = 0;
   int last_pulse = -1;
   int npulse = 0;
   int ivals[$];

   sysclk_ctrl #(.SETTLE_CYC(SETTLE)) uut (
      .src_clk    (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .wr_data    (wr_data),
      .rd_data    (rd_data),
      .bus_resume (bus_resume),
      .vbus_lvl   (vbus_lvl),
      .vbus_pol   (vbus_pol),
      .sys_clk    (sys_clk),
      .ready      (ready)
   );

   always #(CLK_P/2) clk = ~clk;

   // pulse monitor: look a quarter period into each high phase
   always @(posedge clk) begin
      cyc = cyc + 1;
      #(CLK_P/4);
      if (sys_clk) begin
         if (last_pulse >= 0) ivals.push_back(cyc - last_pulse);
         last_pulse = cyc;
         npulse = npulse + 1;
      end
   end

   task automatic check_eq(string req, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   endtask

   task automatic wr(input logic [7:0] d);
      @(negedge clk); wr_en = 1'b1; wr_data = d;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic clr_pulses();
      ivals.delete();
      last_pulse = -1;
      npulse = 0;
   endtask

   task automatic wait_neg(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // started at the falling edge after the starting edge
   task automatic settle_count(output int n);
      n = 0;
      while (!ready && n < 100) begin
         @(negedge clk);
         n++;
      end
   endtask

   initial begin
      #(CLK_P * 200000);
      n_chk++; n_err++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      summary();
   end

   initial begin
      int n;
      int bad;
      int seen_new;
      int ratio;

      // R1: reset state
      wait_neg(3);
      check_eq("R1 reset register", int'(rd_data), 'h80);
      check_eq("R1 ready in reset", int'(ready), 0);
      rst_n = 1'b1;
      settle_count(n);
      check_eq("R4 settle after reset", n, SETTLE);
      check_eq("R4 ready bit reads", int'(rd_data[6]), 1);

      // R3: every ratio code
      for (int s = 0; s < 4; s++) begin
         ratio = 8 >> s;
         wr(8'h80 | 8'(s));
         wait_neg(20);
         clr_pulses();
         wait_neg(48);
         check_eq("R3 pulse count", npulse, 48 / ratio);
         bad = 0;
         foreach (ivals[i]) if (ivals[i] != ratio) bad++;
         check_eq("R3 pulse spacing errors", bad, 0);
      end

      // R2: read-only and unused bits ignore writes
      wr(8'hDF);
      check_eq("R2 field readback", int'(rd_data), 'hC3);

      // R10: wake events while running
      @(negedge clk); bus_resume = 1'b1; vbus_lvl = 1'b1;
      wait_neg(3);
      bus_resume = 1'b0; vbus_lvl = 1'b0;
      @(negedge clk);
      check_eq("R10 register unchanged", int'(rd_data), 'hC3);
      check_eq("R10 ready kept", int'(ready), 1);

      // R11: ratio change at a boundary
      wr(8'h80);
      wait_neg(30);
      clr_pulses();
      wait_neg(11);
      wr(8'h83);
      wait_neg(30);
      bad = 0; seen_new = 0;
      foreach (ivals[i]) begin
         if (ivals[i] == 1) seen_new = 1;
         else if (ivals[i] != 8 || seen_new != 0) bad++;
      end
      check_eq("R11 interval errors", bad, 0);
      check_eq("R11 new ratio reached", seen_new, 1);

      // R6, R5: suspend
      wr(8'hA1);
      check_eq("R5 ready drops on suspend", int'(ready), 0);
      check_eq("R6 suspend reads", int'(rd_data), 'hA1);
      wait_neg(2);
      clr_pulses();
      wait_neg(30);
      check_eq("R6 no pulses suspended", npulse, 0);
      check_eq("R6 still suspended", int'(rd_data[5]), 1);

      // R12: write with suspend=1 and a wake at the same edge
      @(negedge clk); wr_en = 1'b1; wr_data = 8'hA1; bus_resume = 1'b1;
      @(negedge clk); wr_en = 1'b0; bus_resume = 1'b0;
      check_eq("R12 write wins", int'(rd_data), 'hA1);

      // R7: resume wake
      @(negedge clk); bus_resume = 1'b1;
      @(negedge clk); bus_resume = 1'b0;
      check_eq("R7 suspend cleared", int'(rd_data[5]), 0);
      settle_count(n);
      check_eq("R7 settle after resume", n, SETTLE);
      clr_pulses();
      wait_neg(16);
      check_eq("R7 pulses after wake", npulse, 4);

      // R8: bus-power wake, both polarities
      for (int p = 1; p >= 0; p--) begin
         vbus_pol = p[0];
         vbus_lvl = ~p[0];
         wr(8'hA1);
         wait_neg(3);
         check_eq("R8 holds on mismatch", int'(rd_data[5]), 1);
         vbus_lvl = p[0];
         @(negedge clk);
         check_eq("R8 wake on match", int'(rd_data[5]), 0);
         settle_count(n);
         check_eq("R8 settle after wake", n, SETTLE);
         vbus_lvl = ~p[0];
      end

      // R9, R5: disabled block
      wr(8'h01);
      check_eq("R5 ready drops on disable", int'(ready), 0);
      wait_neg(2);
      clr_pulses();
      bus_resume = 1'b1; vbus_lvl = vbus_pol;
      wait_neg(4);
      bus_resume = 1'b0; vbus_lvl = ~vbus_pol;
      wait_neg(16);
      check_eq("R9 no pulses disabled", npulse, 0);
      check_eq("R9 register disabled", int'(rd_data), 'h01);
      wr(8'h21);
      bus_resume = 1'b1; vbus_lvl = vbus_pol;
      wait_neg(4);
      bus_resume = 1'b0; vbus_lvl = ~vbus_pol;
      @(negedge clk);
      check_eq("R9 suspend kept while disabled", int'(rd_data), 'h21);
      wr(8'h81);
      settle_count(n);
      check_eq("R4 settle after enable", n, SETTLE);

      summary();
   end
endmodule